// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Mapper

This block connects an 8 KB cartridge window in a host's 16-bit address space (host addresses 0x6000 to 0x7FFF) to a much larger external ROM of up to 32 MB. To switch banks, the host writes anywhere inside the window. The block ignores the data of that write. It takes the bank number from the write address instead: the byte offset within the window, shifted right by one. A write to 0x6000 therefore selects bank 0, a write to 0x6002 selects bank 1, and so on.

During reads, the block drives the upper ROM address lines from the latched bank and passes the low 13 host address bits straight through. It also asserts the ROM chip enable and output enable. The width of the bank register is a parameter. Eight bits reach 256 banks (2 MB) and twelve bits reach 4096 banks (32 MB). ROM address lines above the bank field are held low.

A 16-bit host store reaches the cartridge as two byte writes to adjacent addresses, with the lower address first. Each byte write is a separate strobe rise, so the second write decides the final bank.

Top module: `cart_bank_mapper`

## Requirements
- R1: During synchronous reset (`rst_n` low at a clock edge) the bank register becomes 0. After reset, reads map to ROM bank 0.
- R2: A rising edge of `wr_stb`, seen at a clock edge while the window is hit, loads the bank register from `host_addr[BANK_W:1]`. This equals (address − 0x6000) >> 1, truncated to BANK_W bits.
- R3: A write strobe held high over several clock edges loads the bank only once, at its first edge. Address changes while the strobe stays high have no effect.
- R4: A strobe rise while `win_sel` is low, or while `host_addr[15:13]` is not 3'b011, leaves the bank unchanged.
- R5: Two byte writes back to back (strobe low for at least one cycle between them) leave the bank taken from the second address. The odd byte of a 16-bit store decodes to the same bank as its even byte.
- R6: `rom_addr` equals {zeros, bank, host_addr[12:0]}. The bank field occupies bits 13 to 13+BANK_W−1.
- R7: `rom_ce_n` is low exactly when `win_sel` is high and `host_addr[15:13]` is 3'b011. `rom_oe_n` is low only when that holds and `wr_stb` is low.
- R8: Host address bits 12 down to BANK_W+1 do not affect the bank. ROM address bits at or above 13+BANK_W are driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 16 | Host address bus |
| wr_stb | input | 1 | Write strobe, active high, synchronous to clk |
| win_sel | input | 1 | Cartridge window select, active high |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |

## Verification
The assertions check the following on every cycle:
- the bank is cleared by reset;
- the bank captures exactly the shifted write address at a load;
- the bank holds between loads;
- a load never repeats on consecutive cycles;
- the bank field appears on the ROM address;
- the enable rules hold, including the unused upper lines staying low.

Only the directed scenarios can show effects across several writes. These include the last-write-wins result of a byte pair, the single capture under a held strobe while the address moves, rejection of writes outside the window, and the truncation of high offset bits with an 8-bit bank.

// File: rtl/cbm_pkg.sv
// Package: shared constants for the cartridge bank mapper.
// Assumes a 16-bit host bus and an 8 KB window at 0x6000.
package cbm_pkg;
    localparam int unsigned HOST_AW  = 16;
    localparam int unsigned WIN_AW   = 13;
    localparam int unsigned SEL_W    = HOST_AW - WIN_AW;
    localparam logic [SEL_W-1:0] WIN_TAG = 3'b011;
endpackage

// File: rtl/cbm_strobe_edge.sv
// Module: detects the rising edge of the host write strobe and qualifies it
// with the window hit. Assumes wr_stb is already synchronous to clk.
module cbm_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic hit,
    output logic load
);
    logic stb_q;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb;
    end

    assign load = stb & ~stb_q & hit;

    // R3: one strobe rise yields exactly one load.
    p_single_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
endmodule

// File: rtl/cbm_bank_reg.sv
// Module: bank register. Loads the write-address bank field on a load pulse.
// Assumes load is a single-cycle pulse from the edge detector.
module cbm_bank_reg #(
    parameter int unsigned BANK_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] bank_in,
    output logic [BANK_W-1:0] bank_q
);
    // Clear on reset; capture the new bank on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    bank_q <= '0;
        else if (load) bank_q <= bank_in;
    end

    // R1: reset clears the bank.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> bank_q == '0);
    // R2: a load captures the presented bank field.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bank_q == $past(bank_in));
    // R4: without a load the bank holds.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_q));
endmodule

// File: rtl/cbm_rom_drive.sv
// Module: forms the ROM address and the enables from the bank and host bus.
// Assumes ROM_AW >= 13 + BANK_W; spare upper lines are tied low.
module cbm_rom_drive
    import cbm_pkg::*;
#(
    parameter int unsigned BANK_W = 12,
    parameter int unsigned ROM_AW = 25
) (
    input  logic              hit,
    input  logic              stb,
    input  logic [BANK_W-1:0] bank,
    input  logic [WIN_AW-1:0] offset,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n
);
    localparam int unsigned PAD_W = ROM_AW - WIN_AW - BANK_W;

    // Pick the address layout depending on whether spare lines exist.
    generate
        if (PAD_W > 0) begin : g_pad
            assign rom_addr = {{PAD_W{1'b0}}, bank, offset};
        end else begin : g_full
            assign rom_addr = {bank, offset};
        end
    endgenerate

    // Enables follow the window hit; output is disabled during a write.
    always_comb begin
        rom_ce_n = ~hit;
        rom_oe_n = ~(hit & ~stb);
    end
endmodule

// File: rtl/cart_bank_mapper.sv
// Module: top of the cartridge bank mapper. A write in the window latches
// address bits [BANK_W:1] as the bank; reads map {bank, addr[12:0]} to ROM.
// Assumes inputs are synchronous to clk and BANK_W is within 8..12.
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int unsigned BANK_W = 12,
    parameter int unsigned ROM_AW = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       host_addr,
    input  logic              wr_stb,
    input  logic              win_sel,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n
);
    localparam int unsigned MAP_W = WIN_AW + BANK_W;

    logic              hit;
    logic              load;
    logic [BANK_W-1:0] bank_q;

    // Window hit: select active and address inside the 8 KB window.
    always_comb hit = win_sel & (host_addr[HOST_AW-1:WIN_AW] == WIN_TAG);

    cbm_strobe_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (wr_stb),
        .hit   (hit),
        .load  (load)
    );

    cbm_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .bank_in (host_addr[BANK_W:1]),
        .bank_q  (bank_q)
    );

    cbm_rom_drive #(.BANK_W(BANK_W), .ROM_AW(ROM_AW)) u_drive (
        .hit      (hit),
        .stb      (wr_stb),
        .bank     (bank_q),
        .offset   (host_addr[WIN_AW-1:0]),
        .rom_addr (rom_addr),
        .rom_ce_n (rom_ce_n),
        .rom_oe_n (rom_oe_n)
    );

    // R6: the bank field of the ROM address carries the latched bank.
    p_bank_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[WIN_AW +: BANK_W] == bank_q);
    // R7: output enable never without chip enable.
    p_oe_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);
    // R7: no output enable during a write strobe.
    p_no_oe_on_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> rom_oe_n);
    // R7: ROM idle when the window is not selected.
    p_idle_unsel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_sel |-> rom_ce_n);

    // R8: spare upper ROM lines stay low.
    generate
        if (ROM_AW > MAP_W) begin : g_chk_pad
            p_upper_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(rom_addr[ROM_AW-1:MAP_W]) == 0);
        end
    endgenerate
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
    localparam int unsigned BW = 8;
    localparam int unsigned AW = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   host_addr = 16'h0000;
    logic          wr_stb = 1'b0;
    logic          win_sel = 1'b0;
    logic [AW-1:0] rom_addr;
    logic          rom_ce_n;
    logic          rom_oe_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cart_bank_mapper #(.BANK_W(BW), .ROM_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .wr_stb(wr_stb),
        .win_sel(win_sel), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected bank from a window byte address.
    function automatic logic [BW-1:0] bank_of(input logic [15:0] a);
        logic [15:0] off;
        off = (a - 16'h6000) >> 1;
        return off[BW-1:0];
    endfunction

    function automatic logic [31:0] map_of(input logic [BW-1:0] b, input logic [15:0] a);
        logic [31:0] r;
        r = 32'(b) << 13;
        return r | 32'(a & 16'h1FFF);
    endfunction

    task automatic do_write(input logic [15:0] a, input logic sel);
        @(negedge clk);
        host_addr = a; win_sel = sel; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [15:0] a, input logic [BW-1:0] b);
        @(negedge clk);
        host_addr = a; win_sel = 1'b1; wr_stb = 1'b0;
        #1;
        check(req, 32'(rom_addr), map_of(b, a));
    endtask

    task automatic t_reset;
        // R1: reset state maps to bank 0
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_check("R1", 16'h6123, 8'h00);
        check("R7", {30'd0, rom_ce_n, rom_oe_n}, 32'd0);
    endtask

    task automatic t_basic;
        do_write(16'h6002, 1'b1);
        read_check("R2", 16'h6ABC, bank_of(16'h6002));
        do_write(16'h61FE, 1'b1);
        read_check("R2", 16'h7FFF, 8'hFF);
        do_write(16'h6000, 1'b1);
        read_check("R6", 16'h6555, 8'h00);
        do_write(16'h60AA, 1'b1);
        read_check("R6", 16'h7234, 8'h55);
    endtask

    task automatic t_high_bits;
        // R8: offset bits above BANK_W ignored, upper ROM lines low
        do_write(16'h7E04, 1'b1);
        read_check("R8", 16'h7FFF, 8'h02);
        check("R8", 32'(rom_addr[AW-1:21]), 32'd0);
    endtask

    task automatic t_rejected;
        do_write(16'h6010, 1'b1);
        do_write(16'h6040, 1'b0);
        read_check("R4", 16'h6000, 8'h08);
        do_write(16'h8002, 1'b1);
        read_check("R4", 16'h6000, 8'h08);
        @(negedge clk);
        host_addr = 16'h6000; win_sel = 1'b0; #1;
        check("R7", {30'd0, rom_ce_n, rom_oe_n}, 32'd3);
        host_addr = 16'hA000; win_sel = 1'b1; #1;
        check("R7", {30'd0, rom_ce_n, rom_oe_n}, 32'd3);
    endtask

    task automatic t_level;
        @(negedge clk);
        host_addr = 16'h6030; win_sel = 1'b1; wr_stb = 1'b1;
        #1;
        check("R7", {30'd0, rom_ce_n, rom_oe_n}, 32'd1);
        @(negedge clk);
        host_addr = 16'h6050;
        @(negedge clk);
        host_addr = 16'h6070;
        @(negedge clk);
        wr_stb = 1'b0;
        read_check("R3", 16'h6000, 8'h18);
    endtask

    task automatic t_pair;
        do_write(16'h6010, 1'b1);
        do_write(16'h6011, 1'b1);
        read_check("R5", 16'h6000, 8'h08);
        do_write(16'h6020, 1'b1);
        do_write(16'h6046, 1'b1);
        read_check("R5", 16'h6000, 8'h23);
    endtask

    task automatic t_reset_mid;
        do_write(16'h6100, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_check("R1", 16'h6008, 8'h00);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_high_bits();
        t_rejected();
        t_level();
        t_pair();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule